// File: doc/BRIEF.md
# Programmable Circular-Buffer Delay Line

This block delays a stream of samples by a number of cycles that can be changed while it runs. It works in one clock domain. Samples reach it after a small clock-crossing FIFO that sits outside the block. One new sample arrives on every clock edge. Each sample is written into a dual-port RAM that is used as a ring. The write index moves forward by one slot on every edge. The read slot is the write index minus the programmed delay, reduced modulo the ring size, so the read address always trails the write address by the delay.

The RAM read is synchronous. That latency is hidden, so the value on `offset` is exactly the number of samples between a sample's arrival and its appearance at the output. When the delay grows, the output valid flag drops until enough new samples have been stored to fill the larger gap, and then the output resumes with the next sample in order. When the delay shrinks, the output stays valid and jumps ahead. The samples in between are dropped, because the input never pauses.

Top module: `prog_delay_line`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `out_valid` is 0. Reset does not clear the RAM.
- R2: Let sample k be the `din` value captured at the k-th rising edge after reset. Let D be the effective delay at that edge. If `out_valid` is 1 after edge k, then `dout` equals sample k−D.
- R3: With an effective delay of 0, `out_valid` is 1 after every edge, and `dout` equals the `din` captured at that same edge.
- R4: An `offset` value above DEPTH−1 behaves exactly like DEPTH−1.
- R5: After reset with a constant delay D, the outputs of edges 0 to D−1 are invalid. The output of edge D is valid and carries sample 0.
- R6: When the effective delay rises from Do to Dn, `out_valid` is 0 for exactly Dn−Do edges, provided at least Do samples were stored. The first valid sample afterwards is the one that follows the last sample emitted before the change.
- R7: When the effective delay falls, `out_valid` stays 1. The samples between the old and new read positions never appear at the output.
- R8: Both ring indices wrap modulo DEPTH, which is a power of two. Long runs keep the exact delay across any number of wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the receiving domain |
| rst | input | 1 | Synchronous reset, active high |
| offset | input | $clog2(DEPTH)+1 | Requested delay in samples. Values above DEPTH−1 are clamped |
| din | input | DATA_W | Input sample, one taken on every edge |
| dout | output | DATA_W | Delayed sample |
| out_valid | output | 1 | `dout` holds a real, correctly delayed sample |

## Verification
The assertions assume that `din` and `offset` hold known values at every rising edge. They allow `offset` to change on any cycle, including jumps past the clamp limit. The delay-growth property compares clamped values of `offset` on consecutive edges. It therefore also assumes that the delay in force during the last reset cycle needs no special treatment: any growth from that cycle is already covered by the start-up blanking. The stimulus changes inputs only on the falling clock edge. It draws `offset` from a range a little wider than the ring, and changes it only now and then, so that runs of constant delay alternate with sudden increases and decreases.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

    // How the effective delay moved between two consecutive edges
    typedef enum logic [1:0] {
        DLY_HOLD   = 2'd0,
        DLY_GROW   = 2'd1,
        DLY_SHRINK = 2'd2
    } dly_change_e;

    function automatic dly_change_e classify_change(input int unsigned prev_d,
                                                    input int unsigned next_d);
        if (next_d > prev_d)      return DLY_GROW;
        else if (next_d < prev_d) return DLY_SHRINK;
        else                      return DLY_HOLD;
    endfunction

endpackage

// File: rtl/pdl_ring_index.sv
module pdl_ring_index #(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] delay,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          bypass
);
    logic [AW-1:0] wr_q;

    // Write slot advances every edge; modulo DEPTH is free truncation
    always_ff @(posedge clk) begin
        if (rst) wr_q <= '0;
        else     wr_q <= wr_q + AW'(1);
    end

    always_comb begin
        wr_addr = wr_q;
        rd_addr = wr_q - delay;
        // Zero delay reads the slot being written this edge: forward the input
        bypass  = (delay == '0);
    end
endmodule

// File: rtl/pdl_ram.sv
module pdl_ram #(
    parameter  int DATA_W = 16,
    parameter  int DEPTH  = 16,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        mem[wr_addr] <= wr_data;
        rd_data      <= mem[rd_addr];
    end
endmodule

// File: rtl/pdl_fill_track.sv
module pdl_fill_track #(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] delay,
    output logic          valid
);
    import pdl_pkg::*;

    localparam logic [AW-1:0] FILL_MAX = AW'(DEPTH - 1);

    logic [AW-1:0] fill_q, prev_d_q;
    logic [AW-1:0] base, fill_n;
    logic          valid_n;
    dly_change_e   chg;

    always_comb begin
        chg  = classify_change(int'(prev_d_q), int'(delay));
        base = fill_q;
        // On growth only the samples that sit behind the old read point count
        if (chg == DLY_GROW && fill_q > prev_d_q) base = prev_d_q;
        valid_n = (base >= delay);
        fill_n  = (base == FILL_MAX) ? base : base + AW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q   <= '0;
            prev_d_q <= '0;
            valid    <= 1'b0;
        end else begin
            fill_q   <= fill_n;
            prev_d_q <= delay;
            valid    <= valid_n;
        end
    end
endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line #(
    parameter  int DATA_W = 16,
    parameter  int DEPTH  = 16,
    localparam int AW     = $clog2(DEPTH),
    localparam int OFS_W  = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OFS_W-1:0]  offset,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              out_valid
);
    localparam logic [OFS_W-1:0] OFS_LIMIT = OFS_W'(DEPTH - 1);

    logic [AW-1:0]     delay;
    logic [AW-1:0]     wr_addr, rd_addr;
    logic              bypass;
    logic              bypass_q;
    logic [DATA_W-1:0] din_q, ram_q;

    // Clamp requests beyond the ring to the longest representable delay
    always_comb begin
        if (offset > OFS_LIMIT) delay = AW'(DEPTH - 1);
        else                    delay = offset[AW-1:0];
    end

    pdl_ring_index #(.DEPTH(DEPTH)) u_index (
        .clk     (clk),
        .rst     (rst),
        .delay   (delay),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .bypass  (bypass)
    );

    pdl_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .clk     (clk),
        .wr_addr (wr_addr),
        .wr_data (din),
        .rd_addr (rd_addr),
        .rd_data (ram_q)
    );

    pdl_fill_track #(.DEPTH(DEPTH)) u_fill (
        .clk   (clk),
        .rst   (rst),
        .delay (delay),
        .valid (out_valid)
    );

    // Forward path aligned with the RAM read register
    always_ff @(posedge clk) begin
        din_q    <= din;
        bypass_q <= bypass;
    end

    assign dout = bypass_q ? din_q : ram_q;
endmodule

// File: rtl/pdl_chk.sv
module pdl_chk #(
    parameter  int DATA_W = 16,
    parameter  int DEPTH  = 16,
    localparam int AW     = $clog2(DEPTH),
    localparam int OFS_W  = AW + 1
) (
    input logic              clk,
    input logic              rst,
    input logic [OFS_W-1:0]  offset,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout,
    input logic              out_valid
);
    function automatic logic [OFS_W-1:0] eff(input logic [OFS_W-1:0] o);
        return (o > OFS_W'(DEPTH - 1)) ? OFS_W'(DEPTH - 1) : o;
    endfunction

    // R1
    reset_blanks_chk: assert property (@(posedge clk) rst |=> !out_valid);

    // R6
    grow_blanks_chk: assert property (@(posedge clk) disable iff (rst)
        (eff(offset) > eff($past(offset))) |=> !out_valid);

    // R3
    zero_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (offset == '0) |=> (out_valid && dout == $past(din)));

    // R2
    unit_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(offset) == OFS_W'(1)) |-> (dout == $past(din, 2)));
endmodule

bind prog_delay_line pdl_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .offset    (offset),
    .din       (din),
    .dout      (dout),
    .out_valid (out_valid)
);

// File: tb/prog_delay_line_bench.sv
module prog_delay_line_bench;
    localparam int DW    = 16;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);
    localparam int OW    = AW + 1;
    localparam int HMAX  = 8192;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [OW-1:0] offset = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          out_valid;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] hist [HMAX];
    int k = 0;
    int m_fill = 0;
    int m_prev = 0;

    always #5 clk = ~clk;

    prog_delay_line #(.DATA_W(DW), .DEPTH(DEPTH)) u_prog_delay_line (
        .clk(clk), .rst(rst), .offset(offset), .din(din),
        .dout(dout), .out_valid(out_valid)
    );

    function automatic int clampd(input int o);
        return (o > DEPTH - 1) ? DEPTH - 1 : o;
    endfunction

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s out_valid actual=%0b expected=%0b edge=%0d", tag, act, exp, k);
        end
    endtask

    task automatic check_data(input string tag, input logic [DW-1:0] act,
                              input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s dout actual=%h expected=%h edge=%0d", tag, act, exp, k);
        end
    endtask

    // One edge: drive at negedge, predict from requirements, sample after posedge
    task automatic step(input logic [DW-1:0] d, input int o, input string tag);
        int dd, base;
        logic expv;
        logic [DW-1:0] expd;
        @(negedge clk);
        din    = d;
        offset = OW'(o);
        dd   = clampd(o);
        base = m_fill;
        if (dd > m_prev && m_fill > m_prev) base = m_prev;
        expv = (base >= dd);
        m_fill = (base + 1 > DEPTH - 1) ? DEPTH - 1 : base + 1;
        m_prev = dd;
        hist[k] = d;
        expd = (k - dd >= 0) ? hist[k - dd] : '0;
        @(posedge clk);
        #1;
        check_bit(tag, out_valid, expv);
        if (expv) check_data(tag, dout, expd);
        k++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 2; i++) begin
            @(posedge clk);
            #1;
            check_bit("R1", out_valid, 1'b0);
        end
        @(negedge clk);
        rst = 1'b0;
        k = 0; m_fill = 0; m_prev = 0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unused_seed;
        int ofs;
        unused_seed = $urandom(1234);
        do_reset();
        // R3 zero delay
        for (int i = 0; i < 8; i++) step(DW'(16'h1000 + i), 0, "R3");
        // R5 startup with delay 6, R1 right after reset
        do_reset();
        step(16'hA000, 6, "R1");
        for (int i = 1; i < 20; i++) step(DW'(16'hA000 + i), 6, "R5");
        // R6 growth 6 -> 10
        for (int i = 0; i < 20; i++) step(DW'(16'hB000 + i), 10, "R6");
        // R7 shrink 10 -> 3
        for (int i = 0; i < 12; i++) step(DW'(16'hC000 + i), 3, "R7");
        // R4 beyond clamp
        for (int i = 0; i < 30; i++) step(DW'(16'hD000 + i), 25, "R4");
        for (int i = 0; i < 10; i++) step(DW'(16'hD100 + i), 31, "R4");
        // R8 wrap many times at full depth
        for (int i = 0; i < 100; i++) step(DW'($urandom()), DEPTH - 1, "R8");
        // R2 random mix
        ofs = 4;
        for (int i = 0; i < 2000; i++) begin
            if ($urandom_range(15) == 0) ofs = int'($urandom_range(20));
            step(DW'($urandom()), ofs, "R2");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule